// File: doc/BRIEF.md
# Subcycle Waveform Timing Engine

This block produces the control waveforms and pattern clocks of a digital stimulus/response tester. Every tester cycle is microcoded as a run of subcycle words in a timing memory. Each word drives the waveform outputs directly for one prescaled period. A sequencer memory holds one tag per tester cycle, and the tag picks which programmed cycle runs next. Consecutive tester cycles can therefore change their timing on the fly.

Flag bits in the subcycle words control the cycle. A word can end the cycle outright, or end it only when the device under test reports ready, which gives synchronous wait states. A word can also stall the engine until selected condition inputs are true. Bits in the sequencer words arm a trigger wait in front of a cycle, raise a marker pulse, request a breakpoint or mark the end of the sequence.

A host loads both memories while the engine is idle. It sets the prescale ratio and then steps the engine with run, pause-mode and return-to-idle controls. Status shows the engine state and whether the last halt came from a breakpoint or from the end of the sequence.

Top module: `tge_engine`

## Requirements
- R1: During reset and on the first clock after it, `eng_state` is 0 (idle), `wave_out` is 0 during reset, and `marker_out`, `halt_brk` and `halt_eos` are 0. State codes: 0 idle, 1 running, 2 paused, 3 waiting for trigger.
- R2: Each subcycle word stays on `wave_out` for exactly N clocks, where N is `prescale_n` and a value of 0 acts as 1. The first word of a started cycle appears on the clock edge that accepts `cmd_run`.
- R3: A cycle begins at timing address tag×4, and its words follow at consecutive addresses. A timing word is {cond-wait[12:10], end-if-ready[9], end-of-cycle[8], wave[7:0]}; a sequencer word is {end-of-sequence[11], breakpoint[10], marker[9], trigger-arm[8], tag[7:0]}. When a word with end-of-cycle set finishes, the next sequencer entry's first word follows with no gap.
- R4: A word with end-if-ready set ends the cycle only if `ready` is high on the last clock of that word. Otherwise the next word follows.
- R5: When a word has cond-wait bit i set and `cond[i]` is low on its last clock, the engine freezes (output and prescaler) until every tested condition is high. Condition bits that the word does not test have no effect.
- R6: A cycle whose sequencer entry has trigger-arm set does not start until `trig` is high on a clock while the engine waits (state 3). Meanwhile the previous output is held. A `trig` pulse while the engine is not waiting is ignored.
- R7: `marker_out` is high for exactly the first clock of a cycle whose marker bit is set, and low at all other times.
- R8: With `pause_mode` high, each accepted run executes exactly one cycle, then the engine pauses (state 2) holding its output. The next run continues with the next sequencer entry.
- R9: After a cycle whose breakpoint bit is set, the engine pauses and sets `halt_brk`. An accepted run clears `halt_brk` and resumes at the next entry.
- R10: After a cycle whose end-of-sequence bit is set, the engine returns to idle and sets `halt_eos`, holding its output. The next run restarts at sequencer entry 0 and clears `halt_eos`.
- R11: `cmd_idle` forces idle on the next edge from any state and rewinds the sequencer to entry 0.
- R12: `cmd_run` while the engine is running has no effect on the waveform trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| tm_we | input | 1 | Timing memory write enable |
| tm_waddr | input | 10 | Timing memory write address |
| tm_wdata | input | 13 | Timing memory write word |
| sq_we | input | 1 | Sequencer memory write enable |
| sq_waddr | input | 6 | Sequencer memory write address |
| sq_wdata | input | 12 | Sequencer memory write word |
| prescale_n | input | 16 | Clocks per subcycle (0 acts as 1) |
| pause_mode | input | 1 | Pause after every cycle |
| cmd_run | input | 1 | Start or resume the sequence |
| cmd_idle | input | 1 | Return to idle and rewind the sequencer |
| ready | input | 1 | Device ready for end-if-ready words |
| cond | input | 3 | Condition inputs tested by cond-wait bits |
| trig | input | 1 | Trigger for armed cycles |
| wave_out | output | 8 | Registered waveform and pattern clock lines |
| marker_out | output | 1 | Marker pulse at start of marked cycles |
| eng_state | output | 2 | Engine state code |
| halt_brk | output | 1 | Last halt came from a breakpoint |
| halt_eos | output | 1 | Last halt came from end of sequence |

## Verification
A wrong subcycle address shows up as a wrong code on `wave_out` within one prescaled period, because every programmed word carries a distinct code. A wrong prescaler count changes how many clocks a code persists, and the bench notices on the first word. A control state that ends, freezes or resumes a cycle in the wrong cycle shifts the code trace by at least one clock at the next word boundary. Errors in the sequencer pointer or the halt flags show up when the state code, a halt flag or the next cycle's first word is checked right after the halting edge.

// File: rtl/tge_pkg.sv
package tge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2,
    ST_TRIG  = 2'd3
  } eng_state_t;
endpackage

// File: rtl/tge_prescaler.sv
module tge_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] n_val,
  input  logic             load,
  input  logic             adv,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] reload;

  assign reload = (n_val == '0) ? '0 : n_val - 1'b1;
  assign tick   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= reload;
    else if (adv)  cnt <= tick ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/tge_wave_store.sv
module tge_wave_store #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] mem [DEPTH];

  // Registered read doubles as the waveform output register.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (rst) rd_word <= '0;
    else     rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/tge_seq_store.sv
module tge_seq_store #(
  parameter int SEQ_AW = 6,
  parameter int WORD_W = 12,
  parameter int LO_W   = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SEQ_AW-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SEQ_AW-1:0] raddr0,
  output logic [WORD_W-1:0] rdata0,
  input  logic [SEQ_AW-1:0] raddr1,
  output logic [LO_W-1:0]   rdata1
);
  localparam int DEPTH = 1 << SEQ_AW;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1][LO_W-1:0];
endmodule

// File: rtl/tge_control.sv
module tge_control import tge_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int TAG_W  = 8,
  parameter int SEQ_AW = 6,
  parameter int NCOND  = 3,
  parameter int SW_W   = TAG_W + 4,
  parameter int GO_W   = TAG_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pause_mode,
  input  logic              cmd_run,
  input  logic              cmd_idle,
  input  logic              ready,
  input  logic [NCOND-1:0]  cond,
  input  logic              trig,
  input  logic              tick,
  input  logic              w_neoc,
  input  logic              w_eir,
  input  logic [NCOND-1:0]  w_cwait,
  input  logic [SW_W-1:0]   sq_cur,
  input  logic [GO_W-1:0]   sq_nxt,
  output logic [SEQ_AW-1:0] seq_ptr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pre_load,
  output logic              pre_adv,
  output logic              marker_out,
  output logic [1:0]        eng_state,
  output logic              halt_brk,
  output logic              halt_eos
);
  localparam int ARM_B = TAG_W;
  localparam int MK_B  = TAG_W + 1;
  localparam int BRK_B = TAG_W + 2;
  localparam int EOS_B = TAG_W + 3;

  eng_state_t        st, st_n;
  logic [ADDR_W-1:0] a_q, a_n;
  logic [SEQ_AW-1:0] s_q, s_n;
  logic              mk_q, mk_n, hb_q, hb_n, he_q, he_n;
  logic              blocked, cyc_end, launch, from_trig;
  logic [GO_W-1:0]   go_w;

  assign blocked = |(w_cwait & ~cond);
  assign cyc_end = (st == ST_RUN) && tick && !blocked && (w_neoc || (w_eir && ready));

  always_comb begin
    st_n      = st;
    a_n       = a_q;
    s_n       = s_q;
    hb_n      = hb_q;
    he_n      = he_q;
    mk_n      = 1'b0;
    pre_load  = 1'b0;
    launch    = 1'b0;
    from_trig = 1'b0;
    go_w      = sq_cur[GO_W-1:0];
    case (st)
      ST_IDLE, ST_PAUSE: begin
        if (cmd_run) begin
          launch = 1'b1;
          hb_n   = 1'b0;
          he_n   = 1'b0;
        end
      end
      ST_TRIG: begin
        if (trig) begin
          launch    = 1'b1;
          from_trig = 1'b1;
        end
      end
      ST_RUN: begin
        if (cyc_end) begin
          if (sq_cur[EOS_B]) begin
            st_n = ST_IDLE;
            s_n  = '0;
            he_n = 1'b1;
          end else begin
            s_n = s_q + 1'b1;
            if (sq_cur[BRK_B]) begin
              st_n = ST_PAUSE;
              hb_n = 1'b1;
            end else if (pause_mode) begin
              st_n = ST_PAUSE;
            end else begin
              launch = 1'b1;
              go_w   = sq_nxt;
            end
          end
        end else if (tick && !blocked) begin
          a_n = a_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (launch) begin
      if (go_w[ARM_B] && !from_trig) begin
        st_n = ST_TRIG;
      end else begin
        st_n     = ST_RUN;
        a_n      = ADDR_W'({go_w[TAG_W-1:0], 2'b00});
        pre_load = 1'b1;
        mk_n     = go_w[MK_B];
      end
    end
    if (cmd_idle) begin
      st_n = ST_IDLE;
      s_n  = '0;
      mk_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      a_q  <= '0;
      s_q  <= '0;
      mk_q <= 1'b0;
      hb_q <= 1'b0;
      he_q <= 1'b0;
    end else begin
      st   <= st_n;
      a_q  <= a_n;
      s_q  <= s_n;
      mk_q <= mk_n;
      hb_q <= hb_n;
      he_q <= he_n;
    end
  end

  assign seq_ptr    = s_q;
  assign rd_addr    = a_n;
  assign pre_adv    = (st == ST_RUN) && !(tick && blocked);
  assign marker_out = mk_q;
  assign eng_state  = st;
  assign halt_brk   = hb_q;
  assign halt_eos   = he_q;

  // R5: a failed condition test freezes the subcycle address
  p_cond_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && tick && blocked && !cmd_idle) |=> (st == ST_RUN && $stable(a_q)));

  // R6: an armed cycle stays parked until a trigger arrives
  p_trig_park_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TRIG && !trig && !cmd_idle) |=> (st == ST_TRIG && $stable(a_q)));

  // R9: breakpoint ends in pause with its flag
  p_brk_pause_r9: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !sq_cur[EOS_B] && sq_cur[BRK_B] && !cmd_idle) |=> (st == ST_PAUSE && hb_q));

  // R10: end of sequence returns to idle with its flag
  p_eos_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && sq_cur[EOS_B] && !cmd_idle) |=> (st == ST_IDLE && he_q && s_q == '0));

  // R11: host idle command rewinds the sequencer
  p_idle_rewind_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_idle |=> (st == ST_IDLE && s_q == '0));

  // R12: a run request while running never restarts the cycle
  p_run_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && cmd_run && !cmd_idle && !tick) |=> $stable(a_q));
endmodule

// File: rtl/tge_engine.sv
module tge_engine #(
  parameter int WAVE_W = 8,
  parameter int ADDR_W = 10,
  parameter int TAG_W  = 8,
  parameter int SEQ_AW = 6,
  parameter int PRE_W  = 16,
  parameter int NCOND  = 3,
  parameter int TW_W   = WAVE_W + 2 + NCOND,
  parameter int SW_W   = TAG_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tm_we,
  input  logic [ADDR_W-1:0] tm_waddr,
  input  logic [TW_W-1:0]   tm_wdata,
  input  logic              sq_we,
  input  logic [SEQ_AW-1:0] sq_waddr,
  input  logic [SW_W-1:0]   sq_wdata,
  input  logic [PRE_W-1:0]  prescale_n,
  input  logic              pause_mode,
  input  logic              cmd_run,
  input  logic              cmd_idle,
  input  logic              ready,
  input  logic [NCOND-1:0]  cond,
  input  logic              trig,
  output logic [WAVE_W-1:0] wave_out,
  output logic              marker_out,
  output logic [1:0]        eng_state,
  output logic              halt_brk,
  output logic              halt_eos
);
  localparam int GO_W   = TAG_W + 2;
  localparam int NEOC_B = WAVE_W;
  localparam int EIR_B  = WAVE_W + 1;
  localparam int CW_LO  = WAVE_W + 2;

  logic [TW_W-1:0]   tw_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [SEQ_AW-1:0] seq_ptr, seq_ptr_nx;
  logic [SW_W-1:0]   sq_cur;
  logic [GO_W-1:0]   sq_nxt;
  logic              tick, pre_load, pre_adv;

  assign seq_ptr_nx = seq_ptr + 1'b1;

  tge_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .n_val(prescale_n),
    .load(pre_load), .adv(pre_adv), .tick(tick)
  );

  tge_seq_store #(.SEQ_AW(SEQ_AW), .WORD_W(SW_W), .LO_W(GO_W)) u_seq (
    .clk(clk), .we(sq_we), .waddr(sq_waddr), .wdata(sq_wdata),
    .raddr0(seq_ptr), .rdata0(sq_cur),
    .raddr1(seq_ptr_nx), .rdata1(sq_nxt)
  );

  tge_wave_store #(.ADDR_W(ADDR_W), .WORD_W(TW_W)) u_wave (
    .clk(clk), .rst(rst), .we(tm_we), .waddr(tm_waddr), .wdata(tm_wdata),
    .rd_addr(rd_addr), .rd_word(tw_q)
  );

  tge_control #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .SEQ_AW(SEQ_AW), .NCOND(NCOND),
    .SW_W(SW_W), .GO_W(GO_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .pause_mode(pause_mode), .cmd_run(cmd_run),
    .cmd_idle(cmd_idle), .ready(ready), .cond(cond), .trig(trig), .tick(tick),
    .w_neoc(tw_q[NEOC_B]), .w_eir(tw_q[EIR_B]), .w_cwait(tw_q[CW_LO +: NCOND]),
    .sq_cur(sq_cur), .sq_nxt(sq_nxt), .seq_ptr(seq_ptr), .rd_addr(rd_addr),
    .pre_load(pre_load), .pre_adv(pre_adv), .marker_out(marker_out),
    .eng_state(eng_state), .halt_brk(halt_brk), .halt_eos(halt_eos)
  );

  assign wave_out = tw_q[WAVE_W-1:0];
endmodule

// File: tb/tge_engine_tb.sv
`timescale 1ns/1ps
module tge_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tm_we = 0, sq_we = 0;
  logic [9:0]  tm_waddr = '0;
  logic [12:0] tm_wdata = '0;
  logic [5:0]  sq_waddr = '0;
  logic [11:0] sq_wdata = '0;
  logic [15:0] prescale_n = 16'd1;
  logic        pause_mode = 0, cmd_run = 0, cmd_idle = 0, ready = 0, trig = 0;
  logic [2:0]  cond = '0;
  logic [7:0]  wave_out;
  logic        marker_out, halt_brk, halt_eos;
  logic [1:0]  eng_state;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tge_engine u_dut (
    .clk(clk), .rst(rst), .tm_we(tm_we), .tm_waddr(tm_waddr), .tm_wdata(tm_wdata),
    .sq_we(sq_we), .sq_waddr(sq_waddr), .sq_wdata(sq_wdata), .prescale_n(prescale_n),
    .pause_mode(pause_mode), .cmd_run(cmd_run), .cmd_idle(cmd_idle), .ready(ready),
    .cond(cond), .trig(trig), .wave_out(wave_out), .marker_out(marker_out),
    .eng_state(eng_state), .halt_brk(halt_brk), .halt_eos(halt_eos)
  );

  function automatic logic [12:0] twd(input logic [7:0] w, input logic ne, input logic er, input logic [2:0] cw);
    return {cw, er, ne, w};
  endfunction
  function automatic logic [11:0] swd(input logic [7:0] t, input logic arm, input logic mk, input logic brk, input logic eos);
    return {eos, brk, mk, arm, t};
  endfunction
  function automatic logic [7:0] wcode(input logic [7:0] t, input int k);
    return {t[3:0], 4'(k)};
  endfunction

  task automatic step(); @(negedge clk); endtask
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask
  task automatic wr_t(input int a, input logic [12:0] d);
    tm_waddr = 10'(a); tm_wdata = d; tm_we = 1; step(); tm_we = 0;
  endtask
  task automatic wr_s(input int a, input logic [11:0] d);
    sq_waddr = 6'(a); sq_wdata = d; sq_we = 1; step(); sq_we = 0;
  endtask
  task automatic prog_cyc(input logic [7:0] t, input int len);
    for (int k = 0; k < len; k++) wr_t(t * 4 + k, twd(wcode(t, k), k == len - 1, 1'b0, 3'b000));
  endtask
  task automatic go(); cmd_run = 1; step(); cmd_run = 0; endtask
  task automatic to_idle(); cmd_idle = 1; step(); cmd_idle = 0; endtask
  task automatic run_cycle(input logic [7:0] t, input int len, input int n, input bit mk, input int poke, input string req);
    for (int k = 0; k < len; k++)
      for (int j = 0; j < n; j++) begin
        chk(req, wave_out, wcode(t, k));
        chk("R7", marker_out, (mk && k == 0 && j == 0) ? 1 : 0);
        if (k == 0 && j == 0) begin
          if (poke == 1) cmd_run = 1;
          if (poke == 2) trig = 1;
        end
        step();
        cmd_run = 0; trig = 0;
      end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ne;
    repeat (3) step();
    // R1 reset state
    chk("R1", wave_out, 0); chk("R1", eng_state, 0); chk("R1", marker_out, 0);
    chk("R1", halt_brk, 0); chk("R1", halt_eos, 0);
    rst = 0; step();
    chk("R1", eng_state, 0); chk("R1", halt_eos, 0);

    prog_cyc(8'h01, 2);
    prog_cyc(8'hC3, 1);
    // R2/R3 sweep over prescale ratio and cycle length
    foreach (ne_list[i]) ;
    for (int L = 1; L <= 4; L++) begin
      prog_cyc(8'h02, L);
      wr_s(0, swd(8'h01, 0, 0, 0, 0)); wr_s(1, swd(8'h02, 0, 0, 0, 0));
      wr_s(2, swd(8'h01, 0, 0, 0, 0)); wr_s(3, swd(8'hC3, 0, 0, 0, 1));
      for (int ni = 0; ni < 5; ni++) begin
        prescale_n = 16'(ne_list[ni]);
        ne = (ne_list[ni] == 0) ? 1 : ne_list[ni];
        to_idle();
        go();
        run_cycle(8'h01, 2, ne, 0, 0, "R2");
        run_cycle(8'h02, L, ne, 0, 0, "R3");
        run_cycle(8'h01, 2, ne, 0, 0, "R3");
        run_cycle(8'hC3, 1, ne, 0, 0, "R10");
        chk("R10", eng_state, 0); chk("R10", halt_eos, 1);
        step(); chk("R10", wave_out, wcode(8'hC3, 0));
      end
    end

    // R10 restart at entry 0, R11 idle rewinds
    prescale_n = 16'd1;
    go(); chk("R10", wave_out, wcode(8'h01, 0)); chk("R10", halt_eos, 0);
    step(); step(); chk("R11", wave_out, wcode(8'h02, 0));
    to_idle(); chk("R11", eng_state, 0);
    step(); chk("R11", eng_state, 0);
    go(); chk("R11", wave_out, wcode(8'h01, 0)); chk("R11", eng_state, 1);
    to_idle();

    // R4 end-if-ready, all ready patterns on the two optional ends
    wr_t(16, twd(wcode(8'h04, 0), 0, 0, 3'b000));
    wr_t(17, twd(wcode(8'h04, 1), 0, 1, 3'b000));
    wr_t(18, twd(wcode(8'h04, 2), 0, 1, 3'b000));
    wr_t(19, twd(wcode(8'h04, 3), 1, 0, 3'b000));
    wr_s(0, swd(8'h04, 0, 0, 0, 0)); wr_s(1, swd(8'hC3, 0, 0, 0, 1));
    for (int p = 0; p < 4; p++) begin
      int el;
      el = p[0] ? 2 : (p[1] ? 3 : 4);
      to_idle(); go();
      for (int k = 0; k < el; k++) begin
        chk("R4", wave_out, wcode(8'h04, k));
        ready = (k == 1) ? p[0] : ((k == 2) ? p[1] : 1'b0);
        step();
      end
      ready = 0;
      chk("R4", wave_out, wcode(8'hC3, 0)); step();
      chk("R4", eng_state, 0);
    end

    // R5 condition waits per condition line and delay
    wr_t(21, twd(wcode(8'h05, 1), 1, 0, 3'b000));
    wr_s(0, swd(8'h05, 0, 0, 0, 0));
    for (int ci = 0; ci < 3; ci++)
      for (int d = 0; d <= 3; d += 3) begin
        cond = '0;
        wr_t(20, twd(wcode(8'h05, 0), 0, 0, 3'(1 << ci)));
        to_idle(); go();
        for (int s = 0; s < d; s++) begin
          chk("R5", wave_out, wcode(8'h05, 0)); step();
        end
        chk("R5", wave_out, wcode(8'h05, 0));
        cond = 3'(1 << ci); step(); cond = '0;
        chk("R5", wave_out, wcode(8'h05, 1)); step();
        chk("R5", wave_out, wcode(8'hC3, 0)); step();
        chk("R5", eng_state, 0);
      end

    // R6 trigger arm, R7 marker
    prescale_n = 16'd2;
    prog_cyc(8'h02, 3);
    wr_s(0, swd(8'h01, 0, 0, 0, 0)); wr_s(1, swd(8'h02, 1, 1, 0, 0));
    wr_s(2, swd(8'hC3, 0, 0, 0, 1));
    to_idle(); go();
    run_cycle(8'h01, 2, 2, 0, 2, "R6");
    chk("R6", eng_state, 3);
    for (int s = 0; s < 3; s++) begin
      chk("R6", wave_out, wcode(8'h01, 1)); chk("R7", marker_out, 0); step();
    end
    trig = 1; step(); trig = 0;
    run_cycle(8'h02, 3, 2, 1, 0, "R6");
    run_cycle(8'hC3, 1, 2, 0, 0, "R6");
    chk("R6", eng_state, 0);

    // R8 pause mode, one cycle per run
    prescale_n = 16'd1; pause_mode = 1;
    wr_s(1, swd(8'h02, 0, 0, 0, 0));
    to_idle(); go();
    run_cycle(8'h01, 2, 1, 0, 0, "R8");
    chk("R8", eng_state, 2);
    step(); chk("R8", wave_out, wcode(8'h01, 1)); step(); chk("R8", eng_state, 2);
    go();
    run_cycle(8'h02, 3, 1, 0, 0, "R8");
    chk("R8", eng_state, 2);
    go();
    run_cycle(8'hC3, 1, 1, 0, 0, "R8");
    chk("R8", eng_state, 0); chk("R8", halt_eos, 1);
    pause_mode = 0;

    // R9 breakpoint, R12 run ignored while running
    prescale_n = 16'd2;
    wr_s(0, swd(8'h01, 0, 0, 1, 0));
    to_idle(); go();
    run_cycle(8'h01, 2, 2, 0, 0, "R9");
    chk("R9", eng_state, 2); chk("R9", halt_brk, 1);
    go(); chk("R9", halt_brk, 0);
    run_cycle(8'h02, 3, 2, 0, 1, "R12");
    run_cycle(8'hC3, 1, 2, 0, 0, "R9");
    chk("R9", eng_state, 0); chk("R9", halt_brk, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int ne_list [5] = '{0, 1, 2, 3, 5};
endmodule